// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave (2 Kbyte, Banked Select)

This block is the slave side of a two-wire (I2C) serial memory with 2048 bytes of storage. A system clock oversamples the bus clock and data lines. The block finds Start and Stop conditions and shifts in a select byte. That byte holds a fixed marker bit, a three-bit chip code compared against three strap pins, the upper three memory address bits and a read/write flag. Writes take a second byte carrying the lower eight address bits, and every byte after it is stored at the running address. Reads stream bytes out from the running address for as long as the master acknowledges.

The data line is driven only through an open-drain enable: when `sda_oe` is high the pad pulls low. A Stop that closes a write starts a modelled internal programming cycle of `WR_CLKS` system clocks. During that cycle `busy` is high and the bus is not watched. One strap pin is compared inverted, so eight parts with distinct strap settings can share one bus.

Top module: `sermem_i2c_slave`

## Requirements
- R1: Until a Start (data falling while clock is high) has been seen, clocked bytes get no acknowledge, and `sda_oe` stays low.
- R2: Select byte bits, most significant first, are [7]=1, [6:4]=chip code, [3:1]=address bits 10..8, [0]=1 read / 0 write. The code matches when it equals {pin2, ~pin1, pin0}, and on a match the slave pulls the data line low in the ninth clock.
- R3: A select byte whose code does not match, or whose bit 7 is 0, gets no acknowledge. The slave goes idle and writes nothing to memory.
- R4: In a write, the byte after the select byte sets address bits 7..0. Each following byte is stored at the running address and acknowledged, and the address then steps by one.
- R5: In a read, the slave sends the byte at the running address, most significant bit first, with bits sampled on clock rising edges. The address then steps by one, and the line is released for the master's ninth-bit response.
- R6: The running address wraps from 2047 to 0 in both reads and writes.
- R7: A master NoAck (line high in the ninth clock) ends the read. The slave keeps the line released and a following Stop leaves it idle.
- R8: A Stop after at least one stored data byte raises `busy` for `WR_CLKS` system clocks. Meanwhile Start conditions are ignored and nothing is acknowledged.
- R9: A repeated Start keeps the running address, so a read after a write of the address alone, or after an earlier read, continues from it.
- R10: After reset `sda_oe` and `busy` are low. `sda_oe` starts driving only while the synchronized bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND of all drivers) |
| ce_pins | input | 3 | Chip strap pins {pin2, pin1, pin0} |
| sda_oe | output | 1 | High pulls the data line low (open drain) |
| busy | output | 1 | High while the modelled programming cycle runs |

## Verification
The assertions assume the bus clock stays in each phase for many system clocks, longer than the synchronizer delay plus one register. They also assume the master changes data only while the bus clock is low, except when it deliberately forms a Start or Stop. The bench keeps 20 system clocks per clock phase and moves its data line at least 5 clocks after a falling clock edge. It models the wired-AND of master and slave drivers itself, so every acknowledge and read bit is taken from the shared line.

// File: rtl/sermem_pkg.sv
package sermem_pkg;
  localparam int BYTE_W = 8;
  localparam int HI_W   = 3;
  localparam int ADDR_W = BYTE_W + HI_W;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RXACK, ST_TX, ST_TXACK, ST_WCYC} st_e;
  typedef enum logic [1:0] {K_SEL, K_ADDR, K_DATA} rxk_e;

  // select byte matches: marker bit set, chip code equals pins with middle pin inverted
  function automatic logic sel_hit(input logic [BYTE_W-1:0] sel, input logic [2:0] pins);
    return sel[7] && (sel[6:4] == {pins[2], ~pins[1], pins[0]});
  endfunction
endpackage

// File: rtl/sermem_busmon.sv
module sermem_busmon #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/sermem_store.sv
module sermem_store #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wr_data;
  end

  assign rd_data = mem[addr];
endmodule

// File: rtl/sermem_wtimer.sv
module sermem_wtimer #(
  parameter int CLKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CLKS + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (go) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (done) busy <= 1'b0;
    end
  end

  assign done = busy && (cnt == CW'(CLKS - 1));

  // R8
  go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) go |-> !busy);
endmodule

// File: rtl/sermem_i2c_slave.sv
module sermem_i2c_slave
  import sermem_pkg::*;
#(
  parameter int WR_CLKS     = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] ce_pins,
  output logic       sda_oe,
  output logic       busy
);
  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  st_e  st;
  rxk_e kind;
  logic [3:0] cnt;
  logic [BYTE_W-1:0] shreg, rd_data;
  logic [ADDR_W-1:0] addr;
  logic rw, nack, wrote, oe_q;
  logic bus_live, rx_done, sel_done, sel_ok, wr_en, wc_go, wc_done;

  sermem_busmon #(.STAGES(SYNC_STAGES)) u_mon (
    .clk, .rst_n, .scl_i, .sda_i, .scl_s, .sda_s,
    .scl_rise, .scl_fall, .start_evt, .stop_evt
  );

  sermem_store #(.AW(ADDR_W), .DW(BYTE_W)) u_mem (
    .clk, .wr_en, .addr, .wr_data(shreg), .rd_data
  );

  sermem_wtimer #(.CLKS(WR_CLKS)) u_tmr (
    .clk, .rst_n, .go(wc_go), .busy, .done(wc_done)
  );

  assign bus_live = (st != ST_WCYC);
  assign rx_done  = bus_live && !start_evt && !stop_evt && (st == ST_RX) && scl_fall && (cnt == 4'd8);
  assign sel_done = rx_done && (kind == K_SEL);
  assign sel_ok   = sel_hit(shreg, ce_pins);
  assign wr_en    = rx_done && (kind == K_DATA);
  assign wc_go    = bus_live && !start_evt && stop_evt && wrote;
  assign sda_oe   = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; kind <= K_SEL; cnt <= '0; shreg <= '0; addr <= '0;
      rw <= 1'b0; nack <= 1'b0; wrote <= 1'b0; oe_q <= 1'b0;
    end else if (bus_live && start_evt) begin
      st <= ST_RX; kind <= K_SEL; cnt <= '0; oe_q <= 1'b0;
    end else if (bus_live && stop_evt) begin
      oe_q <= 1'b0; cnt <= '0; wrote <= 1'b0;
      st <= wrote ? ST_WCYC : ST_IDLE;
    end else begin
      unique case (st)
        ST_RX: begin
          if (scl_rise) begin
            shreg <= {shreg[BYTE_W-2:0], sda_s};
            cnt   <= cnt + 4'd1;
          end else if (rx_done) begin
            cnt <= '0;
            unique case (kind)
              K_SEL: begin
                if (sel_ok) begin
                  oe_q <= 1'b1; rw <= shreg[0];
                  addr[ADDR_W-1:BYTE_W] <= shreg[HI_W:1];
                  st <= ST_RXACK;
                end else st <= ST_IDLE;
              end
              K_ADDR: begin
                addr[BYTE_W-1:0] <= shreg; oe_q <= 1'b1; st <= ST_RXACK;
              end
              default: begin
                addr <= step_addr(addr); wrote <= 1'b1; oe_q <= 1'b1; st <= ST_RXACK;
              end
            endcase
          end
        end
        ST_RXACK: begin
          if (scl_fall) begin
            if (kind == K_SEL && rw) begin
              shreg <= rd_data; oe_q <= ~rd_data[BYTE_W-1];
              addr <= step_addr(addr); st <= ST_TX;
            end else begin
              oe_q <= 1'b0; st <= ST_RX;
              kind <= (kind == K_SEL) ? K_ADDR : K_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) cnt <= cnt + 4'd1;
          else if (scl_fall) begin
            if (cnt == 4'd8) begin
              oe_q <= 1'b0; cnt <= '0; st <= ST_TXACK;
            end else begin
              shreg <= {shreg[BYTE_W-2:0], 1'b0};
              oe_q  <= ~shreg[BYTE_W-2];
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) nack <= sda_s;
          else if (scl_fall) begin
            if (nack) st <= ST_IDLE;
            else begin
              shreg <= rd_data; oe_q <= ~rd_data[BYTE_W-1];
              addr <= step_addr(addr); st <= ST_TX;
            end
          end
        end
        ST_WCYC: if (wc_done) st <= ST_IDLE;
        default: ;
      endcase
    end
  end

  // R10
  drive_low_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> !scl_s);
  // R3
  sel_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_done && !sel_ok) |=> (!sda_oe && st == ST_IDLE));
  // R8
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !sda_oe);
  // R8
  wcyc_entry_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(stop_evt));
  // R5
  tx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TXACK) |-> !sda_oe);
  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '1) |=> (addr == '0));
endmodule

// File: tb/sermem_i2c_slave_bench.sv
module sermem_i2c_slave_bench;
  localparam int WRC = 600;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, msda = 1'b1;
  logic [2:0] ce = 3'b101;
  logic sda_oe, busy;
  wire  sda_line = msda & ~sda_oe;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  sermem_i2c_slave #(.WR_CLKS(WRC)) u_sermem_i2c_slave (
    .clk, .rst_n, .scl_i(scl), .sda_i(sda_line), .ce_pins(ce), .sda_oe, .busy
  );

  // {expect hit, address, data}
  localparam logic [19:0] VEC [0:5] = '{
    {1'b1, 11'h000, 8'hA5}, {1'b1, 11'h7FF, 8'h3C}, {1'b1, 11'h2B4, 8'h0F},
    {1'b1, 11'h500, 8'hF0}, {1'b1, 11'h123, 8'h66}, {1'b0, 11'h123, 8'h99}};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] selb(input logic [2:0] code, input logic [2:0] hi, input logic rd);
    return {1'b1, code, hi, rd};
  endfunction

  function automatic logic [2:0] good_code(input logic [2:0] pins);
    return pins ^ 3'b010;
  endfunction

  task automatic bstart();
    msda = 1'b1; tick(10); scl = 1'b1; tick(20); msda = 1'b0; tick(20); scl = 1'b0; tick(10);
  endtask

  task automatic bstop();
    msda = 1'b0; tick(10); scl = 1'b1; tick(20); msda = 1'b1; tick(20);
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      msda = b[i]; tick(15); scl = 1'b1; tick(20); scl = 1'b0; tick(5);
    end
    msda = 1'b1; tick(15); scl = 1'b1; tick(10); ack = !sda_line; tick(10); scl = 1'b0; tick(5);
  endtask

  task automatic recv(input logic last, output logic [7:0] d);
    msda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(15); scl = 1'b1; tick(10); d[i] = sda_line; tick(10); scl = 1'b0; tick(5);
    end
    msda = last; tick(15); scl = 1'b1; tick(20); scl = 1'b0; tick(5); msda = 1'b1;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 5000 && busy; n++) tick(1);
  endtask

  // set address with a write select, repeated start, read n bytes
  task automatic rd_seq(input logic [10:0] a, input int n, output logic [7:0] d [4]);
    logic k;
    bstart(); send(selb(good_code(ce), a[10:8], 1'b0), k); send(a[7:0], k);
    bstart(); send(selb(good_code(ce), a[10:8], 1'b1), k);
    for (int i = 0; i < n; i++) recv(i == n - 1, d[i]);
    chk(sda_oe == 1'b0, "R7 released after NoAck", int'(sda_oe), 0);
    bstop();
  endtask

  initial begin
    logic a0, a1, a2, a3;
    logic [7:0] d [4];
    logic [2:0] code;
    int bcnt;
    tick(5);
    chk(sda_oe == 1'b0, "R10 reset sda_oe", int'(sda_oe), 0);
    chk(busy == 1'b0, "R10 reset busy", int'(busy), 0);
    rst_n = 1'b1; tick(10);

    // R1: a valid select clocked with no Start
    send(selb(good_code(ce), 3'd0, 1'b0), a0);
    chk(a0 == 1'b0, "R1 no ack without Start", int'(a0), 0);
    bstop(); tick(20);

    // vector table: single-byte writes, read back
    for (int v = 0; v < 6; v++) begin
      code = VEC[v][19] ? good_code(ce) : ce;
      bstart();
      send(selb(code, VEC[v][18:16], 1'b0), a0);
      chk(a0 == VEC[v][19], "R2 select ack", int'(a0), int'(VEC[v][19]));
      if (VEC[v][19]) begin
        send(VEC[v][15:8], a1); send(VEC[v][7:0], a2);
        chk(a1 && a2, "R4 address and data ack", int'({a1, a2}), 3);
      end
      bstop();
      chk(busy == VEC[v][19], "R8 busy after write Stop", int'(busy), int'(VEC[v][19]));
      wait_idle();
      if (VEC[v][19]) begin
        rd_seq(VEC[v][18:8], 1, d);
        chk(d[0] == VEC[v][7:0], "R5 R9 read back", int'(d[0]), int'(VEC[v][7:0]));
      end
    end

    // R3: the unmatched write left the earlier value in place
    rd_seq(11'h123, 1, d);
    chk(d[0] == 8'h66, "R3 mismatch wrote nothing", int'(d[0]), 'h66);

    // R3: marker bit clear
    bstart(); send(selb(good_code(ce), 3'd1, 1'b0) & 8'h7F, a0); bstop();
    chk(a0 == 1'b0, "R3 marker bit zero", int'(a0), 0);

    // R4 R5: sequential write across 3FF/400, sequential read
    bstart(); send(selb(good_code(ce), 3'd3, 1'b0), a0); send(8'hFE, a0);
    send(8'h11, a1); send(8'h22, a2); send(8'h33, a3); bstop();
    chk(a1 && a2 && a3, "R4 data bytes acked", int'({a1, a2, a3}), 7);
    wait_idle();
    rd_seq(11'h3FE, 3, d);
    chk(d[0] == 8'h11, "R4 seq byte 0", int'(d[0]), 'h11);
    chk(d[1] == 8'h22, "R4 seq byte 1", int'(d[1]), 'h22);
    chk(d[2] == 8'h33, "R5 seq byte 2", int'(d[2]), 'h33);

    // R6: write wrap 7FF -> 000, then read wrap
    bstart(); send(selb(good_code(ce), 3'd7, 1'b0), a0); send(8'hFF, a0);
    send(8'hC3, a1); send(8'h5A, a2); bstop();
    // R8: busy length and ignored traffic
    bcnt = 0;
    bstart(); send(selb(good_code(ce), 3'd0, 1'b1), a3);
    chk(a3 == 1'b0, "R8 no ack while busy", int'(a3), 0);
    for (int n = 0; n < 5000 && busy; n++) begin tick(1); bcnt++; end
    chk(bcnt > WRC - 480 && bcnt < WRC - 380, "R8 busy length", bcnt, WRC - 430);
    bstop(); tick(20);
    chk(busy == 1'b0, "R8 Start during busy left no write", int'(busy), 0);
    rd_seq(11'h7FF, 2, d);
    chk(d[0] == 8'hC3, "R6 byte at 7FF", int'(d[0]), 'hC3);
    chk(d[1] == 8'h5A, "R6 wrapped to 000", int'(d[1]), 'h5A);

    // R9: current-address read continues after the last read (now 001)
    bstart(); send(8'h01, a0); bstop();
    bstart(); send(selb(good_code(ce), 3'd0, 1'b0), a0); send(8'h01, a0);
    send(8'h4D, a0); send(8'h8E, a1); bstop(); wait_idle();
    rd_seq(11'h001, 1, d);
    bstart(); send(selb(good_code(ce), 3'd0, 1'b1), a0); recv(1'b1, d[1]); bstop();
    chk(d[0] == 8'h4D, "R9 random read", int'(d[0]), 'h4D);
    chk(d[1] == 8'h8E, "R9 current address read", int'(d[1]), 'h8E);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule